// File: doc/BRIEF.md
# Bit-Serial Two-Operand Adder

This block adds two unsigned operands of `WIDTH` bits each. It uses a single one-bit full-adder cell. A load strobe copies both operands into two shift registers at once. The operands then leave those registers least significant bit first, one bit per clock, and pass through the shared cell. The cell keeps its carry in a flip-flop between bits and registers each sum bit it produces. That registered sum bit is the head of a `WIDTH+1` flop output chain. The rest of the chain is a plain shift register that takes the sum bits in one at a time.

Because the operand registers fill with zeros as they shift, the last step adds the final carry to zero. That step moves the final carry into the top result bit and leaves the carry flop cleared. A one-cycle done pulse marks the cycle in which the chain holds the complete sum. After that pulse, shifting stops and the result stays put until the next load. A new load may be applied at any time: it drops the operation in flight and starts over. Every flop changes only on the rising clock edge, and reset is synchronous.

Top module: `bsa_serial_adder`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears its state. From the next edge on, `done_o` is 0 and `sum_o` is 0 until a load completes.
- R2: A rising edge with `load_i` high captures `opa_i` and `opb_i` in parallel. If `load_i` stays high for several edges, the operands at the last of those edges are the ones added.
- R3: The operands are consumed least significant bit first, with zeros shifted in above. `sum_o` bit k holds sum bit k of the addition. Bit `WIDTH` of `sum_o` holds the final carry, so `sum_o` equals the full unsigned sum `opa_i + opb_i`.
- R4: `done_o` goes high after the (WIDTH+1)-th rising edge that follows the last load edge, and stays high for exactly one cycle. It is low on every cycle before that.
- R5: No carry is left over from one operation into the next. The carry flop is 0 whenever `done_o` is high, and a load clears it. Any operand pair therefore gives its own sum, whatever came before it.
- R6: After the done pulse, `sum_o` holds its value and `done_o` stays low until the next load edge.
- R7: A load during an operation drops that operation. No done pulse appears for it. The next done pulse follows the timing of R4 counted from the new load, and carries the sum of the new operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Parallel load strobe, starts an operation |
| opa_i | input | WIDTH | First operand, unsigned |
| opb_i | input | WIDTH | Second operand, unsigned |
| sum_o | output | WIDTH+1 | Result chain; MSB is the final carry |
| done_o | output | 1 | One-cycle pulse when `sum_o` is complete |

## Verification
The bench targets the following corner cases:
- Operands at full scale, so that the carry runs through every bit position. A design that dropped the last shift step would lose the top result bit.
- An all-ones addition followed at once by small operands. A carry flop that was not cleared would add one to the second sum.
- A load in the middle of an operation, and a load held high over several edges. A design that counted from the first load edge, or kept the old count, would pulse `done_o` too early or report a stale sum.
- The cycles around the pulse. These would expose a done flag that lasts two cycles, or a result that keeps shifting zeros in after it completes.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  typedef struct packed {
    logic sum;
    logic cout;
  } fa_res_t;

  // One-bit full addition of two operand bits and a stored carry.
  function automatic fa_res_t full_add(input logic a, input logic b, input logic cin);
    fa_res_t r;
    r.sum  = a ^ b ^ cin;
    r.cout = (a & b) | (cin & (a ^ b));
    return r;
  endfunction

  // Width of a down-counter that must reach the value n.
  function automatic int unsigned cnt_bits(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction

endpackage

// File: rtl/bsa_opnd_sreg.sv
module bsa_opnd_sreg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             lsb_o
);

  logic [WIDTH-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (load_i)  q <= par_i;
    else if (shift_i) q <= q >> 1;
  end

  assign lsb_o = q[0];

  // Parallel capture of the operand
  p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (q == $past(par_i)));

  // Zero fill at the top while shifting
  p_zero_fill_r3: assert property (@(posedge clk) disable iff (rst)
    (!load_i && shift_i) |=> (q[WIDTH-1] == 1'b0));

  // Register frozen when neither loading nor shifting
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !shift_i) |=> $stable(q));

endmodule

// File: rtl/bsa_add_cell.sv
module bsa_add_cell
  import bsa_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic en_i,
  input  logic a_i,
  input  logic b_i,
  output logic sum_q_o,
  output logic carry_q_o
);

  fa_res_t fa;
  logic    carry_q;
  logic    sum_q;

  assign fa = full_add(a_i, b_i, carry_q);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      carry_q <= 1'b0;
      sum_q   <= 1'b0;
    end else if (en_i) begin
      carry_q <= fa.cout;
      sum_q   <= fa.sum;
    end
  end

  assign sum_q_o   = sum_q;
  assign carry_q_o = carry_q;

  // Both operand bits set always generate a carry
  p_carry_gen_r3: assert property (@(posedge clk) disable iff (rst)
    (en_i && !clr_i && a_i && b_i) |=> carry_q);

  // Both operand bits clear always kill the carry
  p_carry_kill_r3: assert property (@(posedge clk) disable iff (rst)
    (en_i && !clr_i && !a_i && !b_i) |=> !carry_q);

  // A load leaves the carry clear
  p_clr_carry_r5: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !carry_q);

endmodule

// File: rtl/bsa_res_sreg.sv
module bsa_res_sreg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             in_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] q;

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    logic d;
    if (k == WIDTH - 1) begin : g_head
      assign d = in_i;
    end else begin : g_link
      assign d = q[k+1];
    end
    always_ff @(posedge clk) begin
      if (rst || clr_i) q[k] <= 1'b0;
      else if (en_i)    q[k] <= d;
    end
  end

  assign q_o = q;

  // New bit enters at the top of the chain
  p_chain_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (en_i && !clr_i) |=> (q[WIDTH-1] == $past(in_i)));

endmodule

// File: rtl/bsa_seq.sv
module bsa_seq
  import bsa_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic run_o,
  output logic done_o
);

  localparam int unsigned STEPS = WIDTH + 1;
  localparam int unsigned CW    = cnt_bits(STEPS);

  logic [CW-1:0] cnt;
  logic          done_q;
  logic          last_step;

  assign last_step = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      done_q <= 1'b0;
    end else if (load_i) begin
      cnt    <= CW'(STEPS);
      done_q <= 1'b0;
    end else begin
      if (cnt != '0) cnt <= cnt - CW'(1);
      done_q <= last_step;
    end
  end

  assign run_o  = (cnt != '0);
  assign done_o = done_q;

  // Done is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // Done coincides with the end of the run
  p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !run_o);

  // A load never yields done on the next cycle
  p_load_no_done_r7: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (!done_q && run_o));

endmodule

// File: rtl/bsa_serial_adder.sv
module bsa_serial_adder #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic [WIDTH:0]   sum_o,
  output logic             done_o
);

  logic             run;
  logic             step;
  logic             a_bit;
  logic             b_bit;
  logic             sum_q;
  logic             carry_q;
  logic [WIDTH-1:0] tail;

  // One step per cycle while running and not being reloaded
  assign step = run & ~load_i;

  bsa_seq #(.WIDTH(WIDTH)) i_seq (
    .clk    (clk),
    .rst    (rst),
    .load_i (load_i),
    .run_o  (run),
    .done_o (done_o)
  );

  bsa_opnd_sreg #(.WIDTH(WIDTH)) i_opa (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .shift_i (step),
    .par_i   (opa_i),
    .lsb_o   (a_bit)
  );

  bsa_opnd_sreg #(.WIDTH(WIDTH)) i_opb (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .shift_i (step),
    .par_i   (opb_i),
    .lsb_o   (b_bit)
  );

  bsa_add_cell i_cell (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (load_i),
    .en_i      (step),
    .a_i       (a_bit),
    .b_i       (b_bit),
    .sum_q_o   (sum_q),
    .carry_q_o (carry_q)
  );

  bsa_res_sreg #(.WIDTH(WIDTH)) i_res (
    .clk   (clk),
    .rst   (rst),
    .clr_i (load_i),
    .en_i  (step),
    .in_i  (sum_q),
    .q_o   (tail)
  );

  // The registered sum bit heads the (WIDTH+1)-flop result chain
  assign sum_o = {sum_q, tail};

  // No carry survives to the end of an operation
  p_carry_clear_at_done_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !carry_q);

  // Result frozen while idle
  p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!run && !load_i) |=> $stable(sum_o));

endmodule

// File: tb/test_bsa_serial_adder.sv
module test_bsa_serial_adder;

  localparam int unsigned WIDTH  = 8;
  localparam time         CLK_PER = 10ns;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             load_i = 1'b0;
  logic [WIDTH-1:0] opa_i = '0;
  logic [WIDTH-1:0] opb_i = '0;
  logic [WIDTH:0]   sum_o;
  logic             done_o;

  int n_chk  = 0;
  int n_err  = 0;
  bit ended  = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  bsa_serial_adder #(.WIDTH(WIDTH)) i_bsa_serial_adder (
    .clk    (clk),
    .rst    (rst),
    .load_i (load_i),
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .sum_o  (sum_o),
    .done_o (done_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench reference: bitwise ripple addition
  function automatic logic [WIDTH:0] ref_sum(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
    logic [WIDTH:0] r;
    logic c;
    c = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      r[i] = a[i] ^ b[i] ^ c;
      c    = (a[i] & b[i]) | (a[i] & c) | (b[i] & c);
    end
    r[WIDTH] = c;
    return r;
  endfunction

  // Load for a single edge; returns at the falling edge after it
  task automatic start_op(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
    @(negedge clk);
    load_i = 1'b1; opa_i = a; opb_i = b;
    @(negedge clk);
    load_i = 1'b0; opa_i = ~a; opb_i = ~b;
  endtask

  // Called at the falling edge after the last load edge
  task automatic wait_done(input logic [WIDTH:0] exp, input string tag);
    int early;
    early = 0;
    for (int k = 1; k <= WIDTH; k++) begin
      @(negedge clk);
      if (done_o) early++;
    end
    chk({"R4 no early done ", tag}, early, 0);
    @(negedge clk);
    chk({"R4 done pulse ", tag}, int'(done_o), 1);
    chk({"R3 sum ", tag}, int'(sum_o), int'(exp));
    @(negedge clk);
    chk({"R4 single-cycle done ", tag}, int'(done_o), 0);
    chk({"R6 sum held ", tag}, int'(sum_o), int'(exp));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 done after reset", int'(done_o), 0);
    chk("R1 sum after reset", int'(sum_o), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 idle done", int'(done_o), 0);
    chk("R1 idle sum", int'(sum_o), 0);
  endtask

  task automatic t_plain(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b, input string tag);
    start_op(a, b);
    wait_done(ref_sum(a, b), tag);
  endtask

  task automatic t_no_stale_carry;
    t_plain('1, '1, "R5 all-ones");
    t_plain(8'd1, 8'd0, "R5 after carry");
    t_plain(8'd0, 8'd0, "R5 zeros");
  endtask

  task automatic t_hold_long;
    t_plain(8'd100, 8'd27, "R6 hold base");
    repeat (12) @(negedge clk);
    chk("R6 done stays low", int'(done_o), 0);
    chk("R6 sum still held", int'(sum_o), int'(ref_sum(8'd100, 8'd27)));
  endtask

  task automatic t_abort;
    int seen;
    seen = 0;
    start_op(8'hF0, 8'h33);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done_o) seen++;
    end
    start_op(8'h5A, 8'hC3);
    chk("R7 no done for aborted op", seen, 0);
    wait_done(ref_sum(8'h5A, 8'hC3), "R7 restart");
  endtask

  task automatic t_long_load;
    @(negedge clk);
    load_i = 1'b1; opa_i = 8'h11; opb_i = 8'h22;
    @(negedge clk);
    opa_i = 8'h7F; opb_i = 8'h01;
    @(negedge clk);
    opa_i = 8'hAB; opb_i = 8'hCD;
    @(negedge clk);
    chk("R2 no done while loading", int'(done_o), 0);
    load_i = 1'b0; opa_i = '0; opb_i = '0;
    wait_done(ref_sum(8'hAB, 8'hCD), "R2 last load wins");
  endtask

  initial begin
    #(CLK_PER * 200000);
    if (!ended) begin
      ended = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_plain(8'd3, 8'd5, "R3 small");
    t_plain(8'hFF, 8'h01, "R3 full carry chain");
    t_plain(8'hAA, 8'h55, "R3 no carry");
    t_plain(8'h80, 8'h80, "R3 top carry only");
    t_no_stale_carry();
    t_hold_long();
    t_abort();
    t_long_load();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule